// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It reads a three-level radix page table from memory. A translation request carries the virtual address and the physical address of the root table. The walker first checks that the unused upper part of the address is zero. It then reads one 8-byte entry per level, starting at the root. Each valid entry above the last level holds the frame number of the next table page. The last-level entry holds the data frame number, and the walker joins that frame number to the untouched 12-bit page offset.

The block sits behind a translation cache. The cache hands it a miss through a valid/ready request and takes the result through a valid/ready response. Toward memory there is a single read channel: a valid/ready address request, followed some time later by a one-cycle response valid that carries the 64-bit entry. Only one walk is in flight at a time, and the walker never has more than one memory read outstanding.

Top module: `pt_walker`

## Requirements
- R1: After reset, and whenever no walk is in progress, `req_ready` is 1 while `mem_req_valid` and `rsp_valid` are both 0.
- R2: A request whose virtual address has any of bits 63:39 set returns a fault (`rsp_fault`=1, `rsp_paddr`=0) without issuing any memory read.
- R3: The first read of a walk targets the root address plus eight times virtual address bits 38:30.
- R4: Each following read targets (entry bits 53:10 shifted left by 12) plus eight times the next index field: bits 29:21 for the second read and bits 20:12 for the third.
- R5: When all three entries have bit 0 set, the response has `rsp_fault`=0 and `rsp_paddr` = {last entry bits 53:10, virtual address bits 11:0}. Exactly three reads are made. Entry bits 63:54 and 9:1 have no effect.
- R6: An entry with bit 0 clear, at any level, ends the walk at once with `rsp_fault`=1 and `rsp_paddr`=0. No further read is made, so such a walk makes 1, 2 or 3 reads.
- R7: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its response handshake. A request held valid during a walk is neither accepted nor able to disturb that walk.
- R8: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready`. No new read is requested while one is awaiting its response, and a read is never requested while a response is being offered.
- R9: `rsp_valid` stays high with stable `rsp_paddr` and `rsp_fault` until `rsp_ready`.
- R10: The walker waits any number of cycles for `mem_rsp_valid` after a read is accepted, and the translation result does not depend on that latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 56 | Physical address of the root table |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 56 | Translated physical address (0 on fault) |
| rsp_fault | output | 1 | Translation failed |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 56 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present for one cycle |
| mem_rsp_data | input | 64 | Page table entry read from memory |

## Verification
The hardest situation to reach from the ports is a walk that stalls in every phase at once. In such a walk the memory request is refused for several cycles, the data comes back late, the result is held back by the requester, and the next translation request is already waiting on `req_valid` with a different address. The stimulus reaches it by queuing a batch of translations back to back while random backpressure and random memory latency run on every handshake. Each queued address is chosen to end at a different level: a full hit, a fault at each of the three levels, a poisoned leaf, or a non-zero upper-bits fault. A cycle-level reference model follows the walk through every stall.

// File: rtl/pt_walker_pkg.sv
// Shared types for the page table walker.
package pt_walker_pkg;

    // Walk controller phases.
    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_ISSUE = 2'd1,
        WALK_WAIT  = 2'd2,
        WALK_RESP  = 2'd3
    } walk_state_e;

endpackage

// File: rtl/ptw_index_sel.sv
// Entry address generation.
// Picks the table index field of the virtual address for the current level
// and forms base + index * entry size. Also checks that the incoming request
// address has all bits above the translated range clear.
// Assumes: level is always below LEVELS; the base is entry-aligned.
module ptw_index_sel #(
    parameter int VA_W      = 64,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 9,
    parameter int LEVELS    = 3,
    parameter int PA_W      = 56,
    parameter int ENT_BYTES = 8,
    parameter int LVL_W     = 2
) (
    input  logic [VA_W-1:0]  walk_va,
    input  logic [VA_W-1:0]  new_va,
    input  logic [LVL_W-1:0] level,
    input  logic [PA_W-1:0]  base,
    output logic [PA_W-1:0]  entry_addr,
    output logic             canon_ok
);
    localparam int VA_USED   = OFF_W + LEVELS * IDX_W;
    localparam int ENT_SHIFT = $clog2(ENT_BYTES);

    logic [IDX_W-1:0] idx_arr [LEVELS];
    logic [IDX_W-1:0] idx_sel;
    logic             unused_hi;

    // One index field per level, level 0 lowest above the offset.
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_arr[g] = walk_va[OFF_W + g*IDX_W +: IDX_W];
    end

    // Select the index field of the active level.
    always_comb begin
        idx_sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) idx_sel = idx_arr[i];
        end
    end

    assign entry_addr = base + ({{(PA_W-IDX_W){1'b0}}, idx_sel} << ENT_SHIFT);
    assign canon_ok   = (new_va[VA_W-1:VA_USED] == '0);
    assign unused_hi  = ^walk_va[VA_W-1:VA_USED];

endmodule

// File: rtl/ptw_pte_unpack.sv
// Page table entry decode.
// Extracts the valid flag and the frame number from a fetched entry and forms
// the byte base address of the page that frame number names.
// Assumes: PA_W equals frame number width plus OFF_W.
module ptw_pte_unpack #(
    parameter int PTE_W  = 64,
    parameter int PPN_LO = 10,
    parameter int PPN_HI = 53,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 56
) (
    input  logic [PTE_W-1:0]               pte,
    output logic                           pte_valid,
    output logic [PPN_HI-PPN_LO:0]         ppn,
    output logic [PA_W-1:0]                page_base
);
    logic unused_bits;

    assign pte_valid   = pte[0];
    assign ppn         = pte[PPN_HI:PPN_LO];
    assign page_base   = {ppn, {OFF_W{1'b0}}};
    assign unused_bits = ^{pte[PTE_W-1:PPN_HI+1], pte[PPN_LO-1:1]};

endmodule

// File: rtl/ptw_ctrl.sv
// Walk sequencing state machine.
// Idle -> issue read -> wait for data -> (issue next | respond) -> idle.
// Produces the handshake outputs and one-cycle strobes that steer the
// datapath registers in the top module.
// Assumes: mem_rsp_valid is only meaningful while a read is outstanding.
module ptw_ctrl
    import pt_walker_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic canon_ok,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    input  logic pte_valid,
    input  logic at_leaf,
    input  logic rsp_ready,
    output logic req_ready,
    output logic mem_req_valid,
    output logic rsp_valid,
    output logic accept,
    output logic descend,
    output logic done_ok,
    output logic done_fault
);
    walk_state_e state_q, state_d;

    // Next-state and strobe decode.
    always_comb begin
        state_d    = state_q;
        accept     = 1'b0;
        descend    = 1'b0;
        done_ok    = 1'b0;
        done_fault = 1'b0;
        case (state_q)
            WALK_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = canon_ok ? WALK_ISSUE : WALK_RESP;
                end
            end
            WALK_ISSUE: begin
                if (mem_req_ready) state_d = WALK_WAIT;
            end
            WALK_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!pte_valid) begin
                        done_fault = 1'b1;
                        state_d    = WALK_RESP;
                    end else if (at_leaf) begin
                        done_ok = 1'b1;
                        state_d = WALK_RESP;
                    end else begin
                        descend = 1'b1;
                        state_d = WALK_ISSUE;
                    end
                end
            end
            WALK_RESP: begin
                if (rsp_ready) state_d = WALK_IDLE;
            end
            default: state_d = WALK_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WALK_IDLE;
        else        state_q <= state_d;
    end

    assign req_ready     = (state_q == WALK_IDLE);
    assign mem_req_valid = (state_q == WALK_ISSUE);
    assign rsp_valid     = (state_q == WALK_RESP);

endmodule

// File: rtl/pt_walker.sv
// Three-level page table walker top.
// Accepts one translation at a time, reads one entry per level from the root
// downward, and returns either the joined physical address or a fault.
// Assumes: the memory returns exactly one response per accepted read.
module pt_walker #(
    parameter int VA_W   = 64,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 3,
    parameter int PTE_W  = 64,
    parameter int PPN_LO = 10,
    parameter int PPN_HI = 53,
    parameter int PA_W   = PPN_HI - PPN_LO + 1 + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  req_root,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);
    localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int PPN_W     = PPN_HI - PPN_LO + 1;
    localparam int ENT_BYTES = PTE_W / 8;

    logic [VA_W-1:0]  va_q;
    logic [PA_W-1:0]  base_q;
    logic [LVL_W-1:0] level_q;
    logic [PA_W-1:0]  paddr_q;
    logic             fault_q;

    logic             canon_ok;
    logic             pte_valid;
    logic [PPN_W-1:0] leaf_ppn;
    logic [PA_W-1:0]  next_base;
    logic             accept, descend, done_ok, done_fault;
    logic             at_leaf;

    assign at_leaf = (level_q == '0);

    ptw_index_sel #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS),
        .PA_W(PA_W), .ENT_BYTES(ENT_BYTES), .LVL_W(LVL_W)
    ) u_idx (
        .walk_va    (va_q),
        .new_va     (req_vaddr),
        .level      (level_q),
        .base       (base_q),
        .entry_addr (mem_req_addr),
        .canon_ok   (canon_ok)
    );

    ptw_pte_unpack #(
        .PTE_W(PTE_W), .PPN_LO(PPN_LO), .PPN_HI(PPN_HI),
        .OFF_W(OFF_W), .PA_W(PA_W)
    ) u_pte (
        .pte       (mem_rsp_data),
        .pte_valid (pte_valid),
        .ppn       (leaf_ppn),
        .page_base (next_base)
    );

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .canon_ok      (canon_ok),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .pte_valid     (pte_valid),
        .at_leaf       (at_leaf),
        .rsp_ready     (rsp_ready),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .rsp_valid     (rsp_valid),
        .accept        (accept),
        .descend       (descend),
        .done_ok       (done_ok),
        .done_fault    (done_fault)
    );

    // Walk datapath: latch request, step down a level, capture result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            base_q  <= '0;
            level_q <= '0;
            paddr_q <= '0;
            fault_q <= 1'b0;
        end else begin
            if (accept) begin
                va_q    <= req_vaddr;
                base_q  <= req_root;
                level_q <= LVL_W'(LEVELS - 1);
                paddr_q <= '0;
                fault_q <= !canon_ok;
            end
            if (descend) begin
                base_q  <= next_base;
                level_q <= level_q - LVL_W'(1);
            end
            if (done_ok) begin
                paddr_q <= {leaf_ppn, va_q[OFF_W-1:0]};
                fault_q <= 1'b0;
            end
            if (done_fault) begin
                paddr_q <= '0;
                fault_q <= 1'b1;
            end
        end
    end

    assign rsp_paddr = paddr_q;
    assign rsp_fault = fault_q;

endmodule

// File: rtl/pt_walker_chk.sv
// Protocol checker for pt_walker, attached by bind below.
module pt_walker_chk #(
    parameter int VA_W    = 64,
    parameter int VA_USED = 39,
    parameter int PA_W    = 56
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_fault,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr
);
    // R1: ready to accept only with nothing else going on.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !rsp_valid));

    // R2: non-zero upper bits give an immediate fault, no read.
    a_r2_upper_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ((req_vaddr >> VA_USED) != '0))
        |=> (rsp_valid && rsp_fault && !mem_req_valid));

    // R6: a fault always carries a zero address.
    a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R7: no acceptance while a response is pending.
    a_r7_busy_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R8: read request held stable under backpressure.
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R8: accepted read is not followed by another request in the next cycle.
    a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R8: read request and response never offered together.
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && rsp_valid));

    // R9: response held stable under backpressure.
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready)
        |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

endmodule

bind pt_walker pt_walker_chk #(
    .VA_W(VA_W), .VA_USED(OFF_W + LEVELS * IDX_W), .PA_W(PA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/pt_walker_test.sv
// Self-checking bench: memory model with page tables, cycle-level reference.
module pt_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [55:0] req_root = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [55:0] rsp_paddr;
    logic        rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    always #2 clk = ~clk;  // 250 MHz

    pt_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit timed_out = 0;

    // Physical memory holding the tables.
    logic [63:0] pmem [logic [55:0]];
    logic [43:0] next_ppn = 44'h400;

    // Request queue and per-request expected read count and tag.
    logic [63:0] q_va [$];
    logic [55:0] q_root [$];
    int          q_reads [$];
    string       q_tag [$];
    int          responses = 0;

    // Reference model state.
    int          ph = 0;          // 0 idle, 1 issue, 2 wait, 3 respond
    logic [63:0] m_va;
    logic [55:0] m_base;
    int          m_lvl;
    logic [55:0] m_addr;
    logic [55:0] m_held;
    int          m_cd;
    int          m_reads;
    logic [55:0] m_paddr;
    logic        m_fault;
    string       m_tag;

    // Stall knobs (percent / max latency).
    int rdy_pct = 100;
    int lat_max = 0;
    int acc_pct = 100;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [55:0] a);
        return pmem.exists(a) ? pmem[a] : 64'h0;
    endfunction

    function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic v);
        return {10'h2C3, ppn, 9'h0A6, v};
    endfunction

    function automatic logic [55:0] ent(input logic [55:0] base,
                                        input logic [63:0] va, input int lvl);
        logic [63:0] idx;
        idx = (va >> (12 + 9*lvl)) & 64'h1FF;
        return base + 56'(idx * 8);
    endfunction

    task automatic map_page(input logic [55:0] root, input logic [63:0] va,
                            input logic [43:0] frame);
        logic [55:0] base;
        logic [55:0] a;
        logic [63:0] p;
        base = root;
        for (int lvl = 2; lvl >= 1; lvl--) begin
            a = ent(base, va, lvl);
            p = rd(a);
            if (!p[0]) begin
                p = mk_pte(next_ppn, 1'b1);
                next_ppn = next_ppn + 44'd1;
                pmem[a] = p;
            end
            base = {p[53:10], 12'h0};
        end
        pmem[ent(base, va, 0)] = mk_pte(frame, 1'b1);
    endtask

    task automatic poison_leaf(input logic [55:0] root, input logic [63:0] va);
        logic [55:0] base;
        logic [63:0] p;
        base = root;
        for (int lvl = 2; lvl >= 1; lvl--) begin
            p = rd(ent(base, va, lvl));
            base = {p[53:10], 12'h0};
        end
        pmem[ent(base, va, 0)] = mk_pte(44'hABCDE, 1'b0);
    endtask

    task automatic submit(input logic [63:0] va, input logic [55:0] root,
                          input int reads, input string tag);
        q_va.push_back(va);
        q_root.push_back(root);
        q_reads.push_back(reads);
        q_tag.push_back(tag);
    endtask

    // One clock: compare at the negedge, drive inputs, advance the model.
    task automatic step();
        string at;
        logic [63:0] pte;
        case (ph)
            0: begin
                chk(req_ready == 1'b1, "R1", "req_ready idle", 64'(req_ready), 64'h1);
                chk(mem_req_valid == 1'b0, "R1", "mem_req_valid idle", 64'(mem_req_valid), 64'h0);
                chk(rsp_valid == 1'b0, "R1", "rsp_valid idle", 64'(rsp_valid), 64'h0);
            end
            1: begin
                at = (m_lvl == 2) ? "R3" : "R4";
                chk(req_ready == 1'b0, "R7", "req_ready busy", 64'(req_ready), 64'h0);
                chk(mem_req_valid == 1'b1, "R8", "mem_req_valid issue", 64'(mem_req_valid), 64'h1);
                chk(mem_req_addr == m_addr, at, "mem_req_addr", 64'(mem_req_addr), 64'(m_addr));
                chk(rsp_valid == 1'b0, "R8", "rsp_valid issue", 64'(rsp_valid), 64'h0);
            end
            2: begin
                chk(req_ready == 1'b0, "R7", "req_ready wait", 64'(req_ready), 64'h0);
                chk(mem_req_valid == 1'b0, "R8", "mem_req_valid wait", 64'(mem_req_valid), 64'h0);
                chk(rsp_valid == 1'b0, "R10", "rsp_valid wait", 64'(rsp_valid), 64'h0);
            end
            default: begin
                chk(req_ready == 1'b0, "R7", "req_ready resp", 64'(req_ready), 64'h0);
                chk(mem_req_valid == 1'b0, "R8", "mem_req_valid resp", 64'(mem_req_valid), 64'h0);
                chk(rsp_valid == 1'b1, "R9", "rsp_valid", 64'(rsp_valid), 64'h1);
                chk(rsp_fault == m_fault, m_tag, "rsp_fault", 64'(rsp_fault), 64'(m_fault));
                chk(rsp_paddr == m_paddr, m_tag, "rsp_paddr", 64'(rsp_paddr), 64'(m_paddr));
            end
        endcase

        // Drive inputs for this cycle; a queued request stays valid during walks.
        req_valid = (q_va.size() > 0);
        req_vaddr = (q_va.size() > 0) ? q_va[0] : 64'hDEAD_BEEF;
        req_root  = (q_root.size() > 0) ? q_root[0] : 56'h0;
        mem_req_ready = ($urandom_range(0, 99) < rdy_pct);
        rsp_ready     = ($urandom_range(0, 99) < acc_pct);
        if (ph == 2 && m_cd == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd(m_held);
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = {$urandom, $urandom};
        end

        // Advance the reference model over the coming edge.
        case (ph)
            0: if (req_valid) begin
                m_va    = req_vaddr;
                m_base  = req_root;
                m_lvl   = 2;
                m_reads = 0;
                if ((m_va >> 39) != 64'h0) begin
                    ph = 3; m_fault = 1'b1; m_paddr = '0; m_tag = "R2";
                end else begin
                    ph = 1; m_addr = ent(m_base, m_va, m_lvl);
                end
                void'(q_va.pop_front());
                void'(q_root.pop_front());
            end
            1: if (mem_req_ready) begin
                ph = 2;
                m_held = mem_req_addr;
                m_cd = $urandom_range(0, lat_max);
                m_reads++;
            end
            2: if (mem_rsp_valid) begin
                pte = mem_rsp_data;
                if (!pte[0]) begin
                    ph = 3; m_fault = 1'b1; m_paddr = '0; m_tag = "R6";
                end else if (m_lvl == 0) begin
                    ph = 3; m_fault = 1'b0; m_paddr = {pte[53:10], m_va[11:0]};
                    m_tag = (lat_max > 0) ? "R10" : "R5";
                end else begin
                    m_base = {pte[53:10], 12'h0};
                    m_lvl--;
                    m_addr = ent(m_base, m_va, m_lvl);
                    ph = 1;
                end
            end else begin
                m_cd--;
            end
            default: if (rsp_ready) begin
                ph = 0;
                responses++;
                at = q_tag.pop_front();
                chk(m_reads == q_reads[0], at, "read count", 64'(m_reads), 64'(q_reads[0]));
                void'(q_reads.pop_front());
            end
        endcase

        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (cyc > 150000) timed_out = 1;
    endtask

    task automatic drain();
        while ((q_va.size() > 0 || ph != 0) && !timed_out) step();
        step();
    endtask

    localparam logic [55:0] ROOT_A = 56'h10_0000;
    localparam logic [55:0] ROOT_B = 56'h20_0000;

    task automatic batch();
        submit(64'h0000_0000_0000_0123, ROOT_A, 3, "R5");   // all indices 0
        submit(64'h0000_007F_FFFF_FFFF, ROOT_A, 3, "R5");   // all indices 511
        submit(64'h0000_0012_3456_7890, ROOT_B, 3, "R5");   // second root
        submit(64'h0000_0080_0000_0000, ROOT_A, 0, "R2");   // bit 39 set
        submit(64'h8000_0000_0000_1000, ROOT_A, 0, "R2");   // bit 63 set
        submit(64'h0000_0040_0000_0000, ROOT_A, 1, "R6");   // invalid top entry
        submit(64'h0000_0000_0020_0000, ROOT_A, 2, "R6");   // invalid middle entry
        submit(64'h0000_0000_0000_1000, ROOT_A, 3, "R6");   // invalid leaf (absent)
        submit(64'h0000_0000_0000_5ABC, ROOT_A, 3, "R6");   // leaf with valid bit clear
        submit(64'h0000_0012_3456_7FFF, ROOT_B, 3, "R4");   // same path, new offset
    endtask

    initial begin
        map_page(ROOT_A, 64'h0000_0000_0000_0123, 44'h11111);
        map_page(ROOT_A, 64'h0000_007F_FFFF_FFFF, 44'hFFF_FFFF_FFFF);
        map_page(ROOT_B, 64'h0000_0012_3456_7890, 44'h2468A);
        map_page(ROOT_A, 64'h0000_0000_0000_5ABC, 44'h33333);
        poison_leaf(ROOT_A, 64'h0000_0000_0000_5ABC);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "reset req_ready", 64'(req_ready), 64'h1);
        chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", 64'(rsp_valid), 64'h0);
        chk(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", 64'(mem_req_valid), 64'h0);

        // No stalls: one request at a time.
        rdy_pct = 100; lat_max = 0; acc_pct = 100;
        batch();
        drain();

        // Heavy stalls, back-to-back queue (R7, R8, R9, R10).
        rdy_pct = 30; lat_max = 6; acc_pct = 40;
        for (int r = 0; r < 20 && !timed_out; r++) begin
            batch();
            drain();
        end

        if (timed_out) begin
            failures++;
            $display("FAIL watchdog run did not finish responses=%0d", responses);
        end
        chk(responses == 210, "R7", "response count", 64'(responses), 64'd210);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule